// File: doc/BRIEF.md
# Single-Step Word Shifter

This block moves a data word by exactly one bit position per operation. It offers six moves: zero-filling left and right shifts, sign-aware left and right shifts, and left and right rotations. A 3-bit operation code chooses the move, and the word, the code and a qualifying strobe all arrive together. The result is captured in a register one clock later. Alongside it the block reports the bit that left the word, an overflow flag for the sign-aware left shift, and a strobe that marks the new result.

An execution stage uses it as a one-cycle shift slot. In the sign-aware left shift the sign bit stays where it is. Only the bits below it move left, so that move does not behave the same as the plain left shift. Codes outside the six moves hand the word through unchanged. When no strobe is present, the registered outputs keep their last values.

The operation codes are a fixed set of named values: SHL_LOG, SHR_LOG, SHL_ARI, SHR_ARI, ROT_L, ROT_R, and the pass-through group. The output stage has two conditions. It captures when the strobe is high and holds when the strobe is low. A synchronous reset takes it back to cleared.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values of `result`, `shout`, `ovf` and `out_valid` are all zero, whatever the other inputs are.
- R2: `out_valid` equals the previous cycle's `in_valid`. `result`, `shout` and `ovf` update only in the cycle after `in_valid` was high, and otherwise keep their values.
- R3: Code 000 (SHL_LOG): result = din shifted left by one with a 0 entering bit 0; `shout` = din[W-1].
- R4: Code 001 (SHR_LOG): result = din shifted right by one with a 0 entering bit W-1; `shout` = din[0].
- R5: Code 010 (SHL_ARI): result[W-1] = din[W-1], result[W-2:1] = din[W-3:0], result[0] = 0; `shout` = din[W-2]; `ovf` = din[W-1] XOR din[W-2].
- R6: Code 011 (SHR_ARI): result[W-1] = din[W-1], result[W-2:0] = din[W-1:1]; `shout` = din[0].
- R7: Code 100 (ROT_L): result = {din[W-2:0], din[W-1]}; `shout` = din[W-1].
- R8: Code 101 (ROT_R): result = {din[0], din[W-1:1]}; `shout` = din[0].
- R9: Codes 110 and 111: result = din, `shout` = 0, `ovf` = 0.
- R10: `ovf` is 0 after every accepted operation other than code 010.
- R11: Read as two's complement, an SHL_ARI result with `ovf` low equals twice din. An SHR_ARI result equals din divided by two, rounded toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `op` and `din` in this cycle |
| op | input | 3 | Operation code |
| din | input | W | Word to be moved |
| result | output | W | Registered moved word |
| shout | output | 1 | Registered bit that left the word |
| ovf | output | 1 | Registered sign-change flag of SHL_ARI |
| out_valid | output | 1 | Marks a new registered result |

## Verification
The word patterns are chosen to separate the moves. A lone set bit at each end shows which moves drop bits and which wrap them. Words whose top two bits are equal, and words whose top two bits differ, separate SHL_ARI from SHL_LOG and set or clear `ovf`. Words with all bits equal and alternating words show whether the fill bit is 0 or the sign, and an alternating word also shows whether the shift went in the wrong direction. A long pseudo-random run mixes all eight codes, strobe-low gaps and a reset in the middle of traffic. The results are compared every cycle with a model built on integer arithmetic, and the signed multiply and divide relations are checked for the sign-aware moves.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        SHL_LOG = 3'b000,
        SHR_LOG = 3'b001,
        SHL_ARI = 3'b010,
        SHR_ARI = 3'b011,
        ROT_L   = 3'b100,
        ROT_R   = 3'b101,
        PASS_A  = 3'b110,
        PASS_B  = 3'b111
    } shift_op_e;

    typedef enum logic {
        ST_HOLD    = 1'b0,
        ST_CAPTURE = 1'b1
    } stage_e;

endpackage

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_op_e      op,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   moved,
    output logic           lost_bit
);
    localparam int TOP = W - 1;

    always_comb begin
        moved    = din;
        lost_bit = 1'b0;
        unique case (op)
            SHL_LOG: begin
                moved    = {din[TOP-1:0], 1'b0};
                lost_bit = din[TOP];
            end
            SHR_LOG: begin
                moved    = {1'b0, din[TOP:1]};
                lost_bit = din[0];
            end
            SHL_ARI: begin
                moved    = {din[TOP], din[TOP-2:0], 1'b0};
                lost_bit = din[TOP-1];
            end
            SHR_ARI: begin
                moved    = {din[TOP], din[TOP:1]};
                lost_bit = din[0];
            end
            ROT_L: begin
                moved    = {din[TOP-1:0], din[TOP]};
                lost_bit = din[TOP];
            end
            ROT_R: begin
                moved    = {din[0], din[TOP:1]};
                lost_bit = din[0];
            end
            PASS_A, PASS_B: begin
                moved    = din;
                lost_bit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shift_ovf_detect.sv
module shift_ovf_detect
    import shift_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_op_e      op,
    input  logic [W-1:0]   din,
    output logic           sign_flip
);
    localparam int TOP = W - 1;

    always_comb begin
        unique case (op)
            SHL_ARI: sign_flip = din[TOP] ^ din[TOP-1];
            default: sign_flip = 1'b0;
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [2:0]     op,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   result,
    output logic           shout,
    output logic           ovf,
    output logic           out_valid
);
    shift_op_e     op_q;
    stage_e        stage;
    logic [W-1:0]  moved;
    logic          lost_bit;
    logic          sign_flip;

    assign op_q  = shift_op_e'(op);
    assign stage = in_valid ? ST_CAPTURE : ST_HOLD;

    shift_datapath #(.W(W)) u_path (
        .op       (op_q),
        .din      (din),
        .moved    (moved),
        .lost_bit (lost_bit)
    );

    shift_ovf_detect #(.W(W)) u_ovf (
        .op        (op_q),
        .din       (din),
        .sign_flip (sign_flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            shout  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            unique case (stage)
                ST_CAPTURE: begin
                    result <= moved;
                    shout  <= lost_bit;
                    ovf    <= sign_flip;
                end
                ST_HOLD: begin
                    result <= result;
                    shout  <= shout;
                    ovf    <= ovf;
                end
            endcase
        end
    end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [2:0]     op,
    input logic [W-1:0]   din,
    input logic [W-1:0]   result,
    input logic           shout,
    input logic           ovf,
    input logic           out_valid
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && !shout && !ovf && !out_valid)); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(shout) && $stable(ovf))); // R2
    AST_ASL_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'b010) |=> (result[W-1] == $past(din[W-1]) && !result[0])); // R5
    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'b011) |=> (result[W-1] == $past(din[W-1]) && result[W-2] == $past(din[W-1]))); // R6
    AST_ROTATE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b10) |=> ($countones(result) == $countones($past(din)))); // R7
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11) |=> (result == $past(din) && !shout)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != 3'b010) |=> !ovf); // R10
endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .din       (din),
    .result    (result),
    .shout     (shout),
    .ovf       (ovf),
    .out_valid (out_valid)
);

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    op = 3'b000;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  result;
    logic          shout;
    logic          ovf;
    logic          out_valid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [W-1:0]  e_res = '0;
    logic          e_sh  = 1'b0;
    logic          e_ov  = 1'b0;
    logic          e_v   = 1'b0;

    shift_unit #(.W(W)) u_shift_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .din       (din),
        .result    (result),
        .shout     (shout),
        .ovf       (ovf),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string op_tag(input logic v, input logic [2:0] o);
        if (!v) return "R2";
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input logic v, input logic [2:0] o, input logic [W-1:0] d);
        longint unsigned x    = d;
        longint unsigned full = 64'd1 << W;
        longint unsigned msb  = 64'd1 << (W-1);
        e_v = v;
        if (!v) return;
        e_ov = 1'b0;
        e_sh = 1'b0;
        case (o)
            3'd0: begin e_res = W'((x*2) % full);        e_sh = 1'(x / msb); end
            3'd1: begin e_res = W'(x / 2);               e_sh = 1'(x % 2); end
            3'd2: begin
                e_res = W'((x & msb) | ((x*2) % msb));
                e_sh  = 1'((x / (msb/2)) % 2);
                e_ov  = ((x / msb) != ((x / (msb/2)) % 2));
            end
            3'd3: begin e_res = W'(x / 2 + (x & msb));   e_sh = 1'(x % 2); end
            3'd4: begin e_res = W'((x*2) % full + x / msb); e_sh = 1'(x / msb); end
            3'd5: begin e_res = W'(x / 2 + (x % 2) * msb); e_sh = 1'(x % 2); end
            default: begin e_res = d; end
        endcase
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (result !== e_res || shout !== e_sh || ovf !== e_ov || out_valid !== e_v) begin
            n_fail++;
            $display("FAIL %s: res=%h sh=%b ov=%b v=%b expected res=%h sh=%b ov=%b v=%b",
                     tag, result, shout, ovf, out_valid, e_res, e_sh, e_ov, e_v);
        end
    endtask

    // Drive at a falling edge, check at the following falling edge.
    task automatic step(input logic v, input logic [2:0] o, input logic [W-1:0] d);
        int sd;
        int sr;
        int want;
        in_valid = v;
        op       = o;
        din      = d;
        model(v, o, d);
        @(negedge clk);
        compare(op_tag(v, o));
        sd = int'($signed(d));
        sr = int'($signed(result));
        if (v && o == 3'd2 && !e_ov) begin
            n_chk++;
            if (sr != sd * 2) begin
                n_fail++;
                $display("FAIL R11: signed res=%0d expected %0d", sr, sd * 2);
            end
        end
        if (v && o == 3'd3) begin
            want = (sd < 0 && (sd % 2) != 0) ? sd / 2 - 1 : sd / 2;
            n_chk++;
            if (sr != want) begin
                n_fail++;
                $display("FAIL R11: signed res=%0d expected %0d", sr, want);
            end
        end
    endtask

    task automatic reset_check();
        rst      = 1'b1;
        in_valid = 1'b1;
        op       = 3'd4;
        din      = '1;
        @(negedge clk);
        @(negedge clk);
        e_res = '0; e_sh = 1'b0; e_ov = 1'b0; e_v = 1'b0;
        compare("R1");
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        logic [W-1:0] pats [8];
        pats[0] = 16'h8001; pats[1] = 16'h4000; pats[2] = 16'hC000; pats[3] = 16'h7FFF;
        pats[4] = 16'hAAAA; pats[5] = 16'h0000; pats[6] = 16'hFFFF; pats[7] = 16'h5555;

        reset_check();

        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                step(1'b1, 3'(c), pats[p]);
            end
        end

        // Strobe-low cycles must leave outputs untouched (R2).
        step(1'b1, 3'd2, 16'h4000);
        step(1'b0, 3'd0, 16'h1234);
        step(1'b0, 3'd5, 16'hFFFF);
        step(1'b1, 3'd1, 16'h0001);
        step(1'b0, 3'd4, 16'h8000);

        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3] | lf[7], lf[10:8], W'(lf ^ {lf[7:0], lf[15:8]}));
            if (i == 200) begin
                reset_check();
            end
        end

        in_valid = 1'b0;
        finish_run();
    end
endmodule